// File: doc/BRIEF.md
# Quadrature Encoder Timer Slave Controller

This block is a single up/down counter whose behaviour is chosen by a 3-bit slave-mode code. In the encoder modes it follows two quadrature channels. It can count on the edges of channel A only, on the edges of channel B only, or on the edges of both channels. Each counted edge moves the count up or down according to the level of the other channel. In the trigger modes, a rising edge on a separate trigger input does one of three things: it clears the free-running count, it starts a stopped counter, or it acts as the counting clock.

The count runs from zero to a programmable reload value. It wraps at both ends and gives a one-cycle update pulse at each wrap. All three asynchronous inputs pass through two-flop synchronizers before edge detection. Configuration is applied on plain ports, and the count, the direction of the last step and the update pulse come out directly.

Top module: `qenc_slave_timer`

## Requirements
- R1: While rst_ni is low, count_o is 0, dir_o is 0 and update_o is 0.
- R2: Mode 3'b011 counts every single-channel edge. An A edge counts up when the new A level differs from B. A B edge counts up when the new B level equals A. A full cycle with A leading B (AB = 00,10,11,01,00) adds 4, and the reverse cycle subtracts 4.
- R3: Mode 3'b001 counts only A edges and mode 3'b010 counts only B edges, with the same direction rules as R2. One full encoder cycle therefore moves the count by 2.
- R4: In the encoder modes, a synchronized change on both channels in the same cycle is discarded and leaves the count unchanged.
- R5: dir_o becomes 0 after an upward step and 1 after a downward step, and holds its value otherwise.
- R6: With enable_i low, encoder edges, external-clock trigger edges and free-running counting leave count_o unchanged.
- R7: An upward step from a count at or above reload_i gives 0. A downward step from 0 gives reload_i. Each wrap raises update_o for one cycle in the same cycle the new count appears.
- R8: Mode 3'b100 counts up once per clock while enabled. A rising trigger edge clears the count to 0 and raises update_o. When the clear coincides with an upward wrap, the result is 0 and a single update pulse.
- R9: In mode 3'b110, the count holds while enable_i is low until a rising trigger edge. From then on it counts up once per clock, and the trigger itself never changes the count.
- R10: In mode 3'b111, each rising trigger edge adds 1 while enable_i is high.
- R11: The unlisted codes 3'b000 and 3'b101 count up once per clock while enable_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_a_i | input | 1 | Encoder channel A, asynchronous |
| enc_b_i | input | 1 | Encoder channel B, asynchronous |
| trig_i | input | 1 | Trigger input, asynchronous |
| mode_i | input | 3 | Slave-mode code |
| reload_i | input | 16 | Wrap value (maximum count) |
| enable_i | input | 1 | Counter enable |
| count_o | output | 16 | Current count |
| dir_o | output | 1 | 0 after an up step, 1 after a down step |
| update_o | output | 1 | One-cycle pulse on wrap or trigger clear |

## Verification
In reset mode, a trigger clear and the upward wrap at the reload value can land on the same clock edge. The bench first clears the count with one trigger edge and then sets a small reload value. It then times a second trigger edge so that its synchronized rising edge reaches the counter in the exact cycle in which the count sits at the reload value. The result passes only if the count reads 0 afterwards, exactly one update pulse appears in that window, and counting resumes at 1 on the next clock.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef enum logic [2:0] {
    MODE_FREE0   = 3'b000,
    MODE_ENC_A   = 3'b001,
    MODE_ENC_B   = 3'b010,
    MODE_ENC_AB  = 3'b011,
    MODE_CLEAR   = 3'b100,
    MODE_FREE5   = 3'b101,
    MODE_START   = 3'b110,
    MODE_EXT_CLK = 3'b111
  } slave_mode_e;

  typedef struct packed {
    logic inc;
    logic dec;
    logic clear;
  } step_t;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    // [0],[1] synchronizer, [2] previous synchronized level
    logic [2:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[1:0], raw_i[g]};
    end
    assign lvl_o[g]  = sh_q[1];
    assign chg_o[g]  = sh_q[1] ^ sh_q[2];
    assign rise_o[g] = sh_q[1] & ~sh_q[2];
  end
endmodule

// File: rtl/qenc_step_decode.sv
module qenc_step_decode
  import qenc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  [2:0] mode_i,
  input  logic  enable_i,
  input  logic  a_lvl_i,
  input  logic  b_lvl_i,
  input  logic  a_chg_i,
  input  logic  b_chg_i,
  input  logic  t_rise_i,
  output step_t step_o
);
  slave_mode_e mode;
  logic        started_q;
  logic        up_a, up_b, up_ab, enc_ok;

  assign mode   = slave_mode_e'(mode_i);
  assign up_a   = a_lvl_i ^ b_lvl_i;
  assign up_b   = ~(a_lvl_i ^ b_lvl_i);
  assign up_ab  = a_chg_i ? up_a : up_b;
  assign enc_ok = enable_i && !(a_chg_i && b_chg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 started_q <= 1'b0;
    else if (mode != MODE_START) started_q <= 1'b0;
    else if (t_rise_i)           started_q <= 1'b1;
  end

  always_comb begin
    step_o = '0;
    case (mode)
      MODE_ENC_A: if (enc_ok && a_chg_i) begin
        step_o.inc = up_a;
        step_o.dec = ~up_a;
      end
      MODE_ENC_B: if (enc_ok && b_chg_i) begin
        step_o.inc = up_b;
        step_o.dec = ~up_b;
      end
      MODE_ENC_AB: if (enc_ok && (a_chg_i ^ b_chg_i)) begin
        step_o.inc = up_ab;
        step_o.dec = ~up_ab;
      end
      MODE_CLEAR: begin
        step_o.clear = t_rise_i;
        step_o.inc   = enable_i;
      end
      MODE_START:   step_o.inc = enable_i | started_q;
      MODE_EXT_CLK: step_o.inc = enable_i & t_rise_i;
      default:      step_o.inc = enable_i;
    endcase
  end
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  step_t        step_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         dir_o,
  output logic         update_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         dir_q, dir_d, upd_q, upd_d;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    upd_d = 1'b0;
    if (step_i.clear) begin
      cnt_d = '0;
      upd_d = 1'b1;
    end else if (step_i.inc) begin
      dir_d = 1'b0;
      if (cnt_q >= reload_i) begin
        cnt_d = '0;
        upd_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (step_i.dec) begin
      dir_d = 1'b1;
      if (cnt_q == '0) begin
        cnt_d = reload_i;
        upd_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      upd_q <= upd_d;
    end
  end

  assign count_o  = cnt_q;
  assign dir_o    = dir_q;
  assign update_o = upd_q;
endmodule

// File: rtl/qenc_slave_timer.sv
module qenc_slave_timer
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enc_a_i,
  input  logic             enc_b_i,
  input  logic             trig_i,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             enable_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             update_o
);
  localparam int NIN = 3;
  localparam int IA = 0, IB = 1, IT = 2;

  logic [NIN-1:0] lvl, chg, rise;
  step_t          step;

  qenc_sync #(.N(NIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i ({trig_i, enc_b_i, enc_a_i}),
    .lvl_o (lvl),
    .chg_o (chg),
    .rise_o(rise)
  );

  qenc_step_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .enable_i(enable_i),
    .a_lvl_i (lvl[IA]),
    .b_lvl_i (lvl[IB]),
    .a_chg_i (chg[IA]),
    .b_chg_i (chg[IB]),
    .t_rise_i(rise[IT]),
    .step_o  (step)
  );

  qenc_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .reload_i(reload_i),
    .count_o (count_o),
    .dir_o   (dir_o),
    .update_o(update_o)
  );
endmodule

// File: rtl/qenc_slave_timer_chk.sv
module qenc_slave_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             trig_i,
  input logic [2:0]       mode_i,
  input logic [CNT_W-1:0] reload_i,
  input logic             enable_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_o,
  input logic             update_o
);
  // R6
  enc_hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && (mode_i inside {3'b001, 3'b010, 3'b011})) |=> $stable(count_o));

  // R7
  upd_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (count_o == '0 || count_o == $past(reload_i)));

  // R7
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(count_o) <= $past(reload_i) && $stable(reload_i)) |-> count_o <= reload_i);

  // R10
  ext_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b111 && !trig_i && !$past(trig_i) && !$past(trig_i, 2) && !$past(trig_i, 3))
      |=> $stable(count_o));

  // R5
  free_dir_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && mode_i == 3'b000) |=> !dir_o);
endmodule

bind qenc_slave_timer qenc_slave_timer_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/qenc_slave_timer_test.sv
`timescale 1ns/1ps
module qenc_slave_timer_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enc_a_i = 1'b0, enc_b_i = 1'b0, trig_i = 1'b0;
  logic [2:0]  mode_i = 3'b011;
  logic [15:0] reload_i = 16'hFFFF;
  logic        enable_i = 1'b1;
  logic [15:0] count_o;
  logic        dir_o, update_o;

  int checks = 0, errors = 0, upd_seen = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  qenc_slave_timer uut (.*);

  always @(negedge clk_i) if (rst_ni && update_o) upd_seen++;

  task automatic settle();
    @(negedge clk_i);
    #2;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic enc_set(logic a, logic b);
    settle();
    enc_a_i = a;
    enc_b_i = b;
    repeat (4) @(posedge clk_i);
    settle();
  endtask

  task automatic fwd_cycle();
    enc_set(1, 0); enc_set(1, 1); enc_set(0, 1); enc_set(0, 0);
  endtask

  task automatic rev_cycle();
    enc_set(0, 1); enc_set(1, 1); enc_set(1, 0); enc_set(0, 0);
  endtask

  task automatic trig_pulse();
    settle();
    trig_i = 1'b1;
    repeat (3) @(posedge clk_i);
    settle();
    trig_i = 1'b0;
    repeat (3) @(posedge clk_i);
    settle();
  endtask

  task automatic t_reset_state();
    #5;
    chk("R1 count", count_o, 0);
    chk("R1 dir", dir_o, 0);
    chk("R1 update", update_o, 0);
  endtask

  task automatic t_enc_both();
    mode_i = 3'b011;
    fwd_cycle();
    chk("R2 fwd count", count_o, 4);
    chk("R5 dir up", dir_o, 0);
    rev_cycle();
    chk("R2 rev count", count_o, 0);
    chk("R5 dir down", dir_o, 1);
  endtask

  task automatic t_simul();
    enc_set(1, 1);
    chk("R4 both change", count_o, 0);
    enc_set(0, 0);
    chk("R4 both change back", count_o, 0);
  endtask

  task automatic t_enc_single();
    mode_i = 3'b001;
    fwd_cycle();
    chk("R3 mode A fwd", count_o, 2);
    chk("R5 dir up A", dir_o, 0);
    rev_cycle();
    chk("R3 mode A rev", count_o, 0);
    mode_i = 3'b010;
    fwd_cycle();
    chk("R3 mode B fwd", count_o, 2);
    rev_cycle();
    chk("R3 mode B rev", count_o, 0);
    chk("R5 dir down B", dir_o, 1);
  endtask

  task automatic t_enable_low();
    mode_i = 3'b011;
    enable_i = 1'b0;
    fwd_cycle();
    chk("R6 enc disabled", count_o, 0);
    enable_i = 1'b1;
  endtask

  task automatic t_wrap();
    int u0;
    reload_i = 16'd2;
    u0 = upd_seen;
    fwd_cycle();
    chk("R7 up wrap count", count_o, 1);
    chk("R7 up wrap pulses", upd_seen - u0, 1);
    u0 = upd_seen;
    rev_cycle();
    chk("R7 down wrap count", count_o, 0);
    chk("R7 down wrap pulses", upd_seen - u0, 1);
    reload_i = 16'hFFFF;
  endtask

  task automatic t_ext_clk();
    int c0;
    settle();
    mode_i = 3'b111;
    c0 = count_o;
    trig_pulse(); trig_pulse(); trig_pulse();
    chk("R10 three edges", count_o, c0 + 3);
    chk("R5 ext dir", dir_o, 0);
    enable_i = 1'b0;
    trig_pulse();
    chk("R6 ext disabled", count_o, c0 + 3);
  endtask

  task automatic t_free();
    int c0;
    mode_i = 3'b000;
    enable_i = 1'b1;
    c0 = count_o;
    repeat (10) @(posedge clk_i);
    settle();
    chk("R11 code 000", count_o, c0 + 10);
    mode_i = 3'b101;
    repeat (7) @(posedge clk_i);
    settle();
    chk("R11 code 101", count_o, c0 + 17);
    enable_i = 1'b0;
    repeat (5) @(posedge clk_i);
    settle();
    chk("R6 free disabled", count_o, c0 + 17);
  endtask

  task automatic t_clear_mode();
    int u0;
    mode_i = 3'b100;
    enable_i = 1'b1;
    trig_i = 1'b1;
    u0 = upd_seen;
    repeat (3) @(posedge clk_i);
    settle();
    chk("R8 clear count", count_o, 0);
    chk("R8 clear pulse", upd_seen - u0, 1);
    trig_i = 1'b0;
    reload_i = 16'd6;
    repeat (4) @(posedge clk_i);
    settle();
    chk("R8 counting", count_o, 4);
    trig_i = 1'b1;
    u0 = upd_seen;
    repeat (3) @(posedge clk_i);
    settle();
    chk("R8 clear at wrap count", count_o, 0);
    chk("R8 clear at wrap single pulse", upd_seen - u0, 1);
    @(posedge clk_i);
    settle();
    chk("R8 resumes", count_o, 1);
    trig_i = 1'b0;
    repeat (3) @(posedge clk_i);
    settle();
  endtask

  task automatic t_start_mode();
    int c0;
    mode_i = 3'b110;
    enable_i = 1'b0;
    reload_i = 16'hFFFF;
    c0 = count_o;
    repeat (5) @(posedge clk_i);
    settle();
    chk("R9 held", count_o, c0);
    trig_i = 1'b1;
    repeat (3) @(posedge clk_i);
    settle();
    chk("R9 no reset", count_o, c0);
    repeat (5) @(posedge clk_i);
    settle();
    chk("R9 running", count_o, c0 + 5);
    trig_i = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset_state();
    settle();
    rst_ni = 1'b1;
    t_enc_both();
    t_simul();
    t_enc_single();
    t_enable_low();
    t_wrap();
    t_ext_clk();
    t_free();
    t_clear_mode();
    t_start_mode();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule